// File: doc/BRIEF.md
# Coprocessor Sequence Launch Arbiter

This block gathers start requests for processing sequences on a coprocessor and decides which one launches next. Twenty-four requesters feed it: sixteen come from command bits written by the host processor and eight are events from two groups of buffer controllers, four per group. A per-sequence enable vector decides whether a request is accepted. An accepted request sets a pending bit that the host can read back. The bit stays set until that sequence is launched.

When the coprocessor is idle and launching is not paused, the block picks one pending sequence. It emits a one-cycle start pulse carrying the sequence number and its source group, then holds a running flag until the coprocessor answers with a done pulse. Each sequence has a priority of normal or high. High ones are served first. Within a class, host commands beat group A events, group A events beat group B events, and the lowest number wins inside a group. Pause and resume pulses gate launching. A soft clear pulse drops every pending request and the running flag.

Top module: `fc_trigger_arbiter`

## Requirements
- R1: Host command bit k is sequence k (0..15), group A event j is sequence 16+j and group B event j is sequence 20+j. `fc_src` reports the launched sequence's group as 0 for host, 1 for group A and 2 for group B.
- R2: A trigger on an enabled sequence sets its bit in `pend_q` one cycle later. A trigger on a disabled sequence leaves `pend_q` unchanged.
- R3: A pending bit stays set until its sequence is launched. Repeated triggers while it is pending merge into a single launch.
- R4: When something is pending, nothing is running and launching is not paused, `fc_start` pulses for exactly one cycle with `fc_id`. This happens one cycle after the pending bit becomes visible, and in the same cycle that bit clears.
- R5: While any high-priority sequence is pending, no normal-priority sequence is launched.
- R6: Among pending sequences of equal priority, the lowest sequence number wins, which gives host before group A before group B.
- R7: `running` rises together with `fc_start` and falls one cycle after `fc_done` is sampled. No launch happens while it is high, so at least one idle cycle separates launches.
- R8: A `ctl_pause` pulse sets `paused` and blocks a launch at the same edge and afterwards. A running sequence still completes. A `ctl_resume` pulse clears `paused`, and a launch may happen at the next edge. Pause wins when both pulse together.
- R9: A `ctl_reset` pulse clears `pend_q`, `running` and `fc_start` at the next edge. Triggers in the same cycle are discarded. The enables, priorities and `paused` are kept.
- R10: A trigger that arrives in the same cycle as its own sequence's launch leaves the pending bit set, and the sequence launches again later.
- R11: `en_wr` and `pri_wr` load whole vectors; a 1 in `pri_data` means high priority. `rst` (synchronous, active high) clears the enables, priorities, `pend_q`, `running`, `paused` and `fc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_bits | input | CMD_N | Host command trigger bits |
| evt_a | input | GRP_N | Group A buffer events |
| evt_b | input | GRP_N | Group B buffer events |
| en_wr | input | 1 | Enable vector write strobe |
| en_data | input | N_CH | Enable vector |
| pri_wr | input | 1 | Priority vector write strobe |
| pri_data | input | N_CH | Priority vector, 1 = high |
| ctl_pause | input | 1 | Pause launching pulse |
| ctl_resume | input | 1 | Resume launching pulse |
| ctl_reset | input | 1 | Clear pending and running pulse |
| fc_done | input | 1 | Coprocessor finished pulse |
| fc_start | output | 1 | Launch pulse |
| fc_id | output | IDW | Launched sequence number |
| fc_src | output | 2 | Source group of launched sequence |
| pend_q | output | N_CH | Pending status |
| running | output | 1 | A sequence is executing |
| paused | output | 1 | Launching is paused |

## Verification
A trigger and the launch of the same sequence can fall in one cycle. The bench provokes this by holding a host command for two cycles on an idle arbiter. It then expects a start pulse with the pending bit still set and, later, a second launch. A pause pulse and a soft clear can also coincide with triggers. These cases are judged by the behavioural reference model, which is compared every cycle, and by directed checks on `pend_q` and `paused`.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_GRPA = 2'd1,
    SRC_GRPB = 2'd2
  } fc_src_e;

  // map a sequence number to its requesting group
  function automatic fc_src_e src_of(input int idx, input int ncmd, input int ngrp);
    if (idx < ncmd) return SRC_HOST;
    else if (idx < ncmd + ngrp) return SRC_GRPA;
    else return SRC_GRPB;
  endfunction
endpackage

// File: rtl/fc_cfg_regs.sv
module fc_cfg_regs #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_wr,
  input  logic [N-1:0] en_data,
  input  logic         pri_wr,
  input  logic [N-1:0] pri_data,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pri_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pri_q <= '0;
    end else begin
      if (en_wr)  en_q  <= en_data;
      if (pri_wr) pri_q <= pri_data;
    end
  end
endmodule

// File: rtl/fc_pend_bank.sv
module fc_pend_bank #(
  parameter int N   = 24,
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [N-1:0]   trig,
  input  logic           launch,
  input  logic [IDW-1:0] win,
  output logic [N-1:0]   pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic taken;
    assign taken = launch && (win == IDW'(i));
    always_ff @(posedge clk) begin
      if (rst || clr) pend[i] <= 1'b0;
      else            pend[i] <= (pend[i] && !taken) || trig[i];
    end
  end
endmodule

// File: rtl/fc_pick.sv
module fc_pick #(
  parameter int N   = 24,
  parameter int IDW = 5
) (
  input  logic [N-1:0]   pend,
  input  logic [N-1:0]   pri,
  output logic           any,
  output logic [IDW-1:0] win
);
  logic [N-1:0] hi;
  logic [N-1:0] cand;

  assign hi   = pend & pri;
  assign cand = (|hi) ? hi : pend;
  assign any  = |pend;

  // descending scan: the last hit is the lowest index
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) win = IDW'(i);
    end
  end
endmodule

// File: rtl/fc_trigger_arbiter.sv
module fc_trigger_arbiter
  import fc_pkg::*;
#(
  parameter int  CMD_N = 16,
  parameter int  GRP_N = 4,
  localparam int N_CH  = CMD_N + 2 * GRP_N,
  localparam int IDW   = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_N-1:0] cmd_bits,
  input  logic [GRP_N-1:0] evt_a,
  input  logic [GRP_N-1:0] evt_b,
  input  logic             en_wr,
  input  logic [N_CH-1:0]  en_data,
  input  logic             pri_wr,
  input  logic [N_CH-1:0]  pri_data,
  input  logic             ctl_pause,
  input  logic             ctl_resume,
  input  logic             ctl_reset,
  input  logic             fc_done,
  output logic             fc_start,
  output logic [IDW-1:0]   fc_id,
  output logic [1:0]       fc_src,
  output logic [N_CH-1:0]  pend_q,
  output logic             running,
  output logic             paused
);
  logic [N_CH-1:0] en_q;
  logic [N_CH-1:0] pri_q;
  logic [N_CH-1:0] trig;
  logic            any;
  logic [IDW-1:0]  win;
  logic            launch;
  fc_src_e         src_q;

  fc_cfg_regs #(.N(N_CH)) u_cfg (
    .clk(clk), .rst(rst),
    .en_wr(en_wr), .en_data(en_data),
    .pri_wr(pri_wr), .pri_data(pri_data),
    .en_q(en_q), .pri_q(pri_q)
  );

  // sequence numbering puts group order into the index order
  assign trig = {evt_b, evt_a, cmd_bits & {CMD_N{cmd_wr}}} & en_q;

  fc_pick #(.N(N_CH), .IDW(IDW)) u_pick (
    .pend(pend_q), .pri(pri_q), .any(any), .win(win)
  );

  assign launch = any && !running && !paused && !ctl_pause && !ctl_reset;

  fc_pend_bank #(.N(N_CH), .IDW(IDW)) u_pend (
    .clk(clk), .rst(rst), .clr(ctl_reset),
    .trig(trig), .launch(launch), .win(win), .pend(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst || ctl_reset) begin
      running  <= 1'b0;
      fc_start <= 1'b0;
    end else begin
      fc_start <= launch;
      if (launch)       running <= 1'b1;
      else if (fc_done) running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fc_id <= '0;
      src_q <= SRC_HOST;
    end else if (launch) begin
      fc_id <= win;
      src_q <= src_of(int'(win), CMD_N, GRP_N);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             paused <= 1'b0;
    else if (ctl_pause)  paused <= 1'b1;
    else if (ctl_resume) paused <= 1'b0;
  end

  assign fc_src = src_q;
endmodule

// File: rtl/fc_arb_chk.sv
module fc_arb_chk #(
  parameter int N   = 24,
  parameter int IDW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           ctl_reset,
  input logic           ctl_pause,
  input logic           fc_start,
  input logic [IDW-1:0] fc_id,
  input logic [N-1:0]   pend_q,
  input logic [N-1:0]   pri,
  input logic           running,
  input logic           paused
);
  p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
    fc_start |=> !fc_start);

  p_start_from_pending_r4: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> ((($past(pend_q) >> fc_id) & 1) != 0));

  p_high_first_r5: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> (($past(pend_q & pri) == 0) ||
                  ((($past(pend_q & pri) >> fc_id) & 1) != 0)));

  p_no_launch_running_r7: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> !$past(running));

  p_running_with_start_r7: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> running);

  p_no_launch_paused_r8: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> !$past(paused));

  p_pause_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_pause |=> !fc_start);

  p_soft_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ctl_reset |=> (pend_q == '0 && !running && !fc_start));
endmodule

bind fc_trigger_arbiter fc_arb_chk #(.N(N_CH), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .ctl_reset(ctl_reset), .ctl_pause(ctl_pause),
  .fc_start(fc_start), .fc_id(fc_id), .pend_q(pend_q), .pri(pri_q),
  .running(running), .paused(paused)
);

// File: tb/fc_trigger_arbiter_tb.sv
module fc_trigger_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_N = 16;
  localparam int GRP_N = 4;
  localparam int N_CH  = CMD_N + 2 * GRP_N;
  localparam int IDW   = $clog2(N_CH);
  localparam int CP_LAT = 3;
  localparam int WD_CYCLES = 20000;

  logic clk = 0;
  logic rst = 1;
  logic cmd_wr = 0;
  logic [CMD_N-1:0] cmd_bits = '0;
  logic [GRP_N-1:0] evt_a = '0, evt_b = '0;
  logic en_wr = 0, pri_wr = 0;
  logic [N_CH-1:0] en_data = '0, pri_data = '0;
  logic ctl_pause = 0, ctl_resume = 0, ctl_reset = 0;
  logic fc_done = 0;
  logic fc_start;
  logic [IDW-1:0] fc_id;
  logic [1:0] fc_src;
  logic [N_CH-1:0] pend_q;
  logic running, paused;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fc_trigger_arbiter #(.CMD_N(CMD_N), .GRP_N(GRP_N)) u_dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_bits(cmd_bits),
    .evt_a(evt_a), .evt_b(evt_b), .en_wr(en_wr), .en_data(en_data),
    .pri_wr(pri_wr), .pri_data(pri_data), .ctl_pause(ctl_pause),
    .ctl_resume(ctl_resume), .ctl_reset(ctl_reset), .fc_done(fc_done),
    .fc_start(fc_start), .fc_id(fc_id), .fc_src(fc_src), .pend_q(pend_q),
    .running(running), .paused(paused)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // coprocessor stand-in: done pulse CP_LAT cycles after a start
  int cp_cnt = 0;
  always @(negedge clk) begin
    fc_done <= 1'b0;
    if (rst) cp_cnt = 0;
    else if (fc_start) cp_cnt = CP_LAT;
    else if (cp_cnt > 0) begin
      cp_cnt--;
      if (cp_cnt == 0) fc_done <= 1'b1;
    end
  end

  // behavioural reference model
  bit [N_CH-1:0] m_pend, m_en, m_pri;
  bit m_run, m_pau, m_start;
  int m_id;

  function automatic int exp_src(input int id);
    if (id < CMD_N) return 0;
    if (id < CMD_N + GRP_N) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    bit [N_CH-1:0] t;
    bit [N_CH-1:0] hi;
    bit go;
    int w;
    cyc++;
    if (rst) begin
      m_pend = '0; m_en = '0; m_pri = '0;
      m_run = 0; m_pau = 0; m_start = 0; m_id = 0;
    end else begin
      t = '0;
      for (int k = 0; k < CMD_N; k++) if (cmd_wr && cmd_bits[k]) t[k] = 1;
      for (int j = 0; j < GRP_N; j++) begin
        if (evt_a[j]) t[CMD_N + j] = 1;
        if (evt_b[j]) t[CMD_N + GRP_N + j] = 1;
      end
      t = t & m_en;
      hi = m_pend & m_pri;
      w = -1;
      for (int i = 0; i < N_CH; i++)
        if (w < 0 && ((hi != 0) ? hi[i] : m_pend[i])) w = i;
      go = (w >= 0) && !m_run && !m_pau && !ctl_pause && !ctl_reset;
      if (ctl_reset) begin
        m_pend = '0; m_run = 0; m_start = 0;
      end else begin
        if (go) m_pend[w] = 0;
        m_pend = m_pend | t;
        m_start = go;
        if (go) begin m_run = 1; m_id = w; end
        else if (fc_done) m_run = 0;
      end
      if (ctl_pause) m_pau = 1;
      else if (ctl_resume) m_pau = 0;
      if (en_wr) m_en = en_data;
      if (pri_wr) m_pri = pri_data;
    end
  end

  // per-cycle comparison and launch log
  int q_id[$];
  int q_src[$];
  int q_cyc[$];
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk(pend_q == m_pend, "R2 pend_q vs model", pend_q, m_pend);
      chk(fc_start == m_start, "R4 fc_start vs model", fc_start, m_start);
      chk(running == m_run, "R7 running vs model", running, m_run);
      chk(paused == m_pau, "R8 paused vs model", paused, m_pau);
      if (m_start) begin
        chk(fc_id == m_id, "R6 fc_id vs model", fc_id, m_id);
        chk(fc_src == exp_src(m_id), "R1 fc_src vs model", fc_src, exp_src(m_id));
      end
      if (fc_start) begin
        q_id.push_back(int'(fc_id));
        q_src.push_back(int'(fc_src));
        q_cyc.push_back(cyc);
      end
    end
  end

  task automatic pulse_cmd(input logic [CMD_N-1:0] m);
    cmd_wr = 1; cmd_bits = m; @(negedge clk); cmd_wr = 0; cmd_bits = '0;
  endtask
  task automatic pulse_evt(input logic [GRP_N-1:0] a, input logic [GRP_N-1:0] b);
    evt_a = a; evt_b = b; @(negedge clk); evt_a = '0; evt_b = '0;
  endtask
  task automatic pulse_pause();
    ctl_pause = 1; @(negedge clk); ctl_pause = 0;
  endtask
  task automatic pulse_resume();
    ctl_resume = 1; @(negedge clk); ctl_resume = 0;
  endtask
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", WD_CYCLES, WD_CYCLES);
    finish_run();
  end

  initial begin
    int n5;
    int n9;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(pend_q == '0 && !running && !fc_start && !paused, "R11 reset state",
        {pend_q, running, fc_start, paused}, 0);

    // R11 config load: all enabled except 7; sequence 20 high priority
    en_wr = 1; en_data = ~(N_CH'(1) << 7); pri_wr = 1; pri_data = N_CH'(1) << 20;
    @(negedge clk);
    en_wr = 0; pri_wr = 0;

    // R2 R3 R1: collect requests while paused
    pulse_pause();
    pulse_cmd(16'h00A8);          // bits 3, 5, 7
    pulse_evt(4'b0010, 4'b0001);  // sequences 17 and 20
    pulse_cmd(16'h0020);          // repeated 5
    chk(pend_q == ((N_CH'(1) << 3) | (N_CH'(1) << 5) | (N_CH'(1) << 17) | (N_CH'(1) << 20)),
        "R2 pending mask with disabled 7", pend_q,
        (N_CH'(1) << 3) | (N_CH'(1) << 5) | (N_CH'(1) << 17) | (N_CH'(1) << 20));
    chk(q_id.size() == 0, "R8 no launch while paused", q_id.size(), 0);
    pulse_resume();
    wait_cyc(40);
    chk(q_id.size() == 4, "R3 four launches", q_id.size(), 4);
    if (q_id.size() == 4) begin
      chk(q_id[0] == 20, "R5 high priority first", q_id[0], 20);
      chk(q_id[1] == 3, "R6 lowest host first", q_id[1], 3);
      chk(q_id[2] == 5, "R6 host before group A", q_id[2], 5);
      chk(q_id[3] == 17, "R6 group A last", q_id[3], 17);
      chk(q_src[0] == 2, "R1 group B source", q_src[0], 2);
      chk(q_src[3] == 1, "R1 group A source", q_src[3], 1);
      chk(q_src[1] == 0, "R1 host source", q_src[1], 0);
      for (int i = 1; i < 4; i++)
        chk(q_cyc[i] - q_cyc[i-1] >= CP_LAT + 2, "R7 launch spacing",
            q_cyc[i] - q_cyc[i-1], CP_LAT + 2);
    end
    n5 = 0;
    foreach (q_id[i]) if (q_id[i] == 5) n5++;
    chk(n5 == 1, "R3 merged retrigger", n5, 1);
    q_id.delete(); q_src.delete(); q_cyc.delete();

    // R4 launch timing
    pulse_cmd(16'h0010);
    chk(pend_q[4] && !fc_start, "R4 pending visible first", {pend_q[4], fc_start}, 2'b10);
    @(negedge clk);
    chk(fc_start && fc_id == 4 && !pend_q[4], "R4 start and clear",
        {fc_start, fc_id, pend_q[4]}, {1'b1, IDW'(4), 1'b0});
    wait_cyc(10);
    q_id.delete(); q_src.delete(); q_cyc.delete();

    // R8 pause while running
    pulse_cmd(16'h0001);
    @(negedge clk);
    chk(running, "R8 sequence 0 running", running, 1);
    pulse_pause();
    pulse_cmd(16'h0002);
    wait_cyc(8);
    chk(!running, "R8 running sequence finished", running, 0);
    chk(pend_q[1], "R8 request held while paused", pend_q[1], 1);
    chk(q_id.size() == 1, "R8 no launch while paused", q_id.size(), 1);
    pulse_resume();
    chk(!paused && !fc_start, "R8 resumed, no start yet", {paused, fc_start}, 0);
    @(negedge clk);
    chk(fc_start && fc_id == 1, "R8 launch after resume", {fc_start, fc_id}, {1'b1, IDW'(1)});
    wait_cyc(10);
    q_id.delete(); q_src.delete(); q_cyc.delete();

    // R10 trigger during own launch
    cmd_wr = 1; cmd_bits = 16'h0200;
    wait_cyc(2);
    cmd_wr = 0; cmd_bits = '0;
    chk(fc_start && fc_id == 9 && pend_q[9], "R10 retrigger kept pending",
        {fc_start, fc_id, pend_q[9]}, {1'b1, IDW'(9), 1'b1});
    wait_cyc(20);
    n9 = 0;
    foreach (q_id[i]) if (q_id[i] == 9) n9++;
    chk(n9 == 2, "R10 relaunch count", n9, 2);

    // R9 soft clear with a trigger in the same cycle
    pulse_pause();
    pulse_cmd(16'h0044);
    ctl_reset = 1; cmd_wr = 1; cmd_bits = 16'h0800;
    @(negedge clk);
    ctl_reset = 0; cmd_wr = 0; cmd_bits = '0;
    chk(pend_q == '0 && !running, "R9 soft clear", {pend_q, running}, 0);
    chk(paused, "R9 pause kept", paused, 1);
    pulse_resume();
    pulse_cmd(16'h0004);
    @(negedge clk);
    chk(fc_start && fc_id == 2, "R9 enables kept", {fc_start, fc_id}, {1'b1, IDW'(2)});
    wait_cyc(10);
    finish_run();
  end
endmodule